// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns a 16-bit address into one select line for the on-chip target that owns that address. The targets are internal RAM, a 64-byte control register block, a boot ROM, an EEPROM, an EPROM and external memory. All selects are combinational from the address, the mode pins and the configuration enables. A small placement register, held inside the register block, decides where RAM and the register block sit. Software can move each of them to any 4 KB page. The register block always takes precedence over RAM when the two overlap.

The operating mode decides three things: whether the boot ROM is visible, which 64-byte window is flagged as the interrupt vector area, and whether addresses that nothing claims go out to external memory. When no target claims an address, the block raises an unmapped flag and asserts no select. The memories themselves sit outside this block.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset the placement register holds RAM page 0 and register page 1. RAM therefore covers $0000–$01FF and the register block covers $1000–$103F.
- R2: The placement register is written by a one-cycle `wr_en` whose address equals the current register page base plus offset $03D. `wr_data[7:4]` becomes the RAM page and `wr_data[3:0]` becomes the register page, effective from the next cycle. A `wr_en` at any other address leaves the placement unchanged.
- R3: `sel_reg` covers page base to base+63. `sel_ram` covers RAM page base to base+RAM_BYTES-1, which is 512 bytes by default.
- R4: When RAM and the register block share a page, addresses base..base+63 select the register block. RAM answers from base+64 up to its end.
- R5: EEPROM ($B600–$B7FF) is decoded only while `eeprom_en`=1, and EPROM ($D000–$FFFF) only while `eprom_en`=1. With an enable low, those addresses fall through to lower-priority targets.
- R6: The boot ROM ($BF00–$BFFF) is selected only in the special modes, `mode`=2'b10 (bootstrap) and 2'b11 (test).
- R7: `sel_ext` is asserted for addresses that no on-chip target claims, and only in `mode`=2'b01 (expanded) or 2'b11 (test).
- R8: In `mode`=2'b00 (single-chip) and 2'b10 (bootstrap), an unclaimed address asserts no select and sets `unmapped`=1. `unmapped` is 1 exactly when no select is asserted.
- R9: When targets overlap, the fixed priority from highest to lowest is register block, RAM, boot ROM, EEPROM, EPROM, external.
- R10: `vec_hit` flags $FFC0–$FFFF in modes 2'b00 and 2'b01, and $BFC0–$BFFF in modes 2'b10 and 2'b11.
- R11: At most one select is asserted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Address bus |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data for the placement register |
| mode | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| eeprom_en | input | 1 | EEPROM present in the map |
| eprom_en | input | 1 | EPROM present in the map |
| sel_reg | output | 1 | Register block select |
| sel_ram | output | 1 | RAM select |
| sel_boot | output | 1 | Boot ROM select |
| sel_eeprom | output | 1 | EEPROM select |
| sel_eprom | output | 1 | EPROM select |
| sel_ext | output | 1 | External memory select |
| unmapped | output | 1 | No target claims the address |
| vec_hit | output | 1 | Address is in the active vector window |

## Verification
The bench places RAM and the register block on the same page and probes the 64th and 65th bytes. A design with the wrong overlap rule would hand the low bytes to RAM or stop RAM too early. It also moves the placement register and then writes at the old address of the register block. A design that decoded the write against a fixed address would move the map a second time. The bench drops each configuration enable and probes the same address in single-chip and expanded modes, where a wrong fall-through rule would either keep the select or fail to route the address outside. Finally, it moves RAM over the EPROM range and steps across the boot ROM and vector windows in each mode, which exposes a swapped priority or a vector window that ignores the mode.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W = 16;
    localparam int PAGE_W = 4;
    localparam int OFS_W  = ADDR_W - PAGE_W;
    localparam int NUM_TGT = 6;

    // target indices, highest priority first
    localparam int T_REG    = 0;
    localparam int T_RAM    = 1;
    localparam int T_BOOT   = 2;
    localparam int T_EEPROM = 3;
    localparam int T_EPROM  = 4;
    localparam int T_EXT    = 5;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_EXPAND = 2'b01,
        MODE_BOOT   = 2'b10,
        MODE_TEST   = 2'b11
    } opmode_e;

    typedef logic [NUM_TGT-1:0] tgt_vec_t;
    typedef logic [ADDR_W:0]    wide_addr_t;

    typedef struct packed {
        logic [PAGE_W-1:0] ram_page;
        logic [PAGE_W-1:0] reg_page;
    } map_cfg_t;

    localparam map_cfg_t MAP_RESET = '{ram_page: 4'h0, reg_page: 4'h1};

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input wide_addr_t lo,
                                       input wide_addr_t span);
        wide_addr_t wa;
        wa = {1'b0, a};
        return (wa >= lo) && (wa < lo + span);
    endfunction

    function automatic wide_addr_t page_base(input logic [PAGE_W-1:0] pg);
        return {1'b0, pg, {OFS_W{1'b0}}};
    endfunction

    function automatic logic is_special(input opmode_e m);
        return m == MODE_BOOT || m == MODE_TEST;
    endfunction

    function automatic logic ext_allowed(input opmode_e m);
        return m == MODE_EXPAND || m == MODE_TEST;
    endfunction

endpackage

// File: rtl/memmap_cfg_reg.sv
module memmap_cfg_reg
    import memmap_pkg::*;
#(
    parameter logic [OFS_W-1:0] MAP_OFFSET = 12'h03D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output map_cfg_t          cfg,
    output logic              wr_hit
);

    // the register answers at its own current location
    assign wr_hit = wr_en
                 && (addr[ADDR_W-1:OFS_W] == cfg.reg_page)
                 && (addr[OFS_W-1:0] == MAP_OFFSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= MAP_RESET;
        end else if (wr_hit) begin
            cfg <= map_cfg_t'(wr_data);
        end
    end

endmodule

// File: rtl/memmap_hit_gen.sv
module memmap_hit_gen
    import memmap_pkg::*;
#(
    parameter int         RAM_BYTES  = 512,
    parameter int         REG_BYTES  = 64,
    parameter wide_addr_t BOOT_BASE  = 17'h0BF00,
    parameter int         BOOT_BYTES = 256,
    parameter wide_addr_t EE_BASE    = 17'h0B600,
    parameter int         EE_BYTES   = 512,
    parameter wide_addr_t EP_BASE    = 17'h0D000,
    parameter int         EP_BYTES   = 12288
) (
    input  logic [ADDR_W-1:0] addr,
    input  map_cfg_t          cfg,
    input  opmode_e           mode,
    input  logic              eeprom_en,
    input  logic              eprom_en,
    output tgt_vec_t          raw
);

    localparam wide_addr_t RAM_SPAN  = wide_addr_t'(RAM_BYTES);
    localparam wide_addr_t REG_SPAN  = wide_addr_t'(REG_BYTES);
    localparam wide_addr_t BOOT_SPAN = wide_addr_t'(BOOT_BYTES);
    localparam wide_addr_t EE_SPAN   = wide_addr_t'(EE_BYTES);
    localparam wide_addr_t EP_SPAN   = wide_addr_t'(EP_BYTES);

    always_comb begin
        raw           = '0;
        raw[T_REG]    = in_window(addr, page_base(cfg.reg_page), REG_SPAN);
        raw[T_RAM]    = in_window(addr, page_base(cfg.ram_page), RAM_SPAN);
        raw[T_BOOT]   = is_special(mode) && in_window(addr, BOOT_BASE, BOOT_SPAN);
        raw[T_EEPROM] = eeprom_en && in_window(addr, EE_BASE, EE_SPAN);
        raw[T_EPROM]  = eprom_en && in_window(addr, EP_BASE, EP_SPAN);
        raw[T_EXT]    = ext_allowed(mode);
    end

endmodule

// File: rtl/memmap_prio.sv
module memmap_prio #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    logic [N:0] taken;

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]   = req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
    end

endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import memmap_pkg::*;
#(
    parameter int         RAM_BYTES  = 512,
    parameter int         REG_BYTES  = 64,
    parameter int         VEC_BYTES  = 64,
    parameter wide_addr_t VEC_NORMAL = 17'h0FFC0,
    parameter wide_addr_t VEC_SPEC   = 17'h0BFC0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  mode,
    input  logic        eeprom_en,
    input  logic        eprom_en,
    output logic        sel_reg,
    output logic        sel_ram,
    output logic        sel_boot,
    output logic        sel_eeprom,
    output logic        sel_eprom,
    output logic        sel_ext,
    output logic        unmapped,
    output logic        vec_hit
);

    localparam wide_addr_t VEC_SPAN = wide_addr_t'(VEC_BYTES);

    opmode_e  op_mode;
    map_cfg_t map_q;
    logic     wr_hit;
    tgt_vec_t raw_hits;
    tgt_vec_t grants;

    assign op_mode = opmode_e'(mode);

    memmap_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (map_q),
        .wr_hit  (wr_hit)
    );

    memmap_hit_gen #(
        .RAM_BYTES (RAM_BYTES),
        .REG_BYTES (REG_BYTES)
    ) u_hits (
        .addr      (addr),
        .cfg       (map_q),
        .mode      (op_mode),
        .eeprom_en (eeprom_en),
        .eprom_en  (eprom_en),
        .raw       (raw_hits)
    );

    memmap_prio #(.N(NUM_TGT)) u_prio (
        .req   (raw_hits),
        .grant (grants)
    );

    assign sel_reg    = grants[T_REG];
    assign sel_ram    = grants[T_RAM];
    assign sel_boot   = grants[T_BOOT];
    assign sel_eeprom = grants[T_EEPROM];
    assign sel_eprom  = grants[T_EPROM];
    assign sel_ext    = grants[T_EXT];
    assign unmapped   = ~|raw_hits;

    assign vec_hit = in_window(addr, is_special(op_mode) ? VEC_SPEC : VEC_NORMAL, VEC_SPAN);

endmodule

// File: rtl/memmap_checker.sv
module memmap_checker
    import memmap_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic [1:0]  mode,
    input logic        eeprom_en,
    input logic        eprom_en,
    input logic        sel_reg,
    input logic        sel_ram,
    input logic        sel_boot,
    input logic        sel_eeprom,
    input logic        sel_eprom,
    input logic        sel_ext,
    input logic        unmapped,
    input logic        vec_hit,
    input logic        wr_hit,
    input map_cfg_t    cfg
);

    logic [5:0] sels;
    assign sels = {sel_ext, sel_eprom, sel_eeprom, sel_boot, sel_ram, sel_reg};

    assert_one_select_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sels));

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
        unmapped == (sels == 6'b0));

    assert_ext_mode_R7: assert property (@(posedge clk) disable iff (rst)
        sel_ext |-> mode[0]);

    assert_boot_mode_R6: assert property (@(posedge clk) disable iff (rst)
        sel_boot |-> mode[1]);

    assert_eeprom_off_R5: assert property (@(posedge clk) disable iff (rst)
        !eeprom_en |-> !sel_eeprom);

    assert_eprom_off_R5: assert property (@(posedge clk) disable iff (rst)
        !eprom_en |-> !sel_eprom);

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(cfg));

    assert_reg_page_R3: assert property (@(posedge clk) disable iff (rst)
        sel_reg |-> (addr[15:12] == cfg.reg_page && addr[11:6] == 6'b0));

    assert_vec_window_R10: assert property (@(posedge clk) disable iff (rst)
        vec_hit |-> (addr[15:6] == (mode[1] ? 10'h2FF : 10'h3FF)));

endmodule

bind mem_map_decoder memmap_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .mode       (mode),
    .eeprom_en  (eeprom_en),
    .eprom_en   (eprom_en),
    .sel_reg    (sel_reg),
    .sel_ram    (sel_ram),
    .sel_boot   (sel_boot),
    .sel_eeprom (sel_eeprom),
    .sel_eprom  (sel_eprom),
    .sel_ext    (sel_ext),
    .unmapped   (unmapped),
    .vec_hit    (vec_hit),
    .wr_hit     (wr_hit),
    .cfg        (map_q)
);

// File: tb/mem_map_decoder_tb.sv
module mem_map_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  mode = 2'b00;
    logic        eeprom_en = 1'b1;
    logic        eprom_en = 1'b1;
    logic        sel_reg, sel_ram, sel_boot, sel_eeprom, sel_eprom, sel_ext;
    logic        unmapped, vec_hit;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    // bench copy of the placement, updated from the bench's own writes
    logic [3:0] m_ram = 4'h0;
    logic [3:0] m_reg = 4'h1;

    always #2 clk = ~clk;

    mem_map_decoder u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .mode(mode), .eeprom_en(eeprom_en), .eprom_en(eprom_en),
        .sel_reg(sel_reg), .sel_ram(sel_ram), .sel_boot(sel_boot),
        .sel_eeprom(sel_eeprom), .sel_eprom(sel_eprom), .sel_ext(sel_ext),
        .unmapped(unmapped), .vec_hit(vec_hit)
    );

    // {vec_hit, unmapped, ext, eprom, eeprom, boot, ram, reg}
    function automatic logic [7:0] expect_out(input logic [15:0] a, input logic [1:0] md,
                                              input logic ee, input logic ep,
                                              input logic [3:0] rp, input logic [3:0] gp);
        logic [5:0] s;
        logic       v;
        int         ai;
        int         rb;
        int         gb;
        ai = int'(a);
        rb = int'(rp) * 4096;
        gb = int'(gp) * 4096;
        s  = '0;
        if (ai >= gb && ai < gb + 64)                     s[0] = 1'b1;
        else if (ai >= rb && ai < rb + 512)               s[1] = 1'b1;
        else if (md[1] && ai >= 'hBF00 && ai <= 'hBFFF)   s[2] = 1'b1;
        else if (ee && ai >= 'hB600 && ai <= 'hB7FF)      s[3] = 1'b1;
        else if (ep && ai >= 'hD000)                      s[4] = 1'b1;
        else if (md == 2'b01 || md == 2'b11)              s[5] = 1'b1;
        v = md[1] ? (ai >= 'hBFC0 && ai <= 'hBFFF) : (ai >= 'hFFC0);
        return {v, (s == 6'b0), s};
    endfunction

    task automatic probe(input logic [15:0] a, input logic [1:0] md, input logic ee,
                         input logic ep, input string tag);
        logic [7:0] got;
        logic [7:0] exp;
        @(negedge clk);
        addr = a; mode = md; eeprom_en = ee; eprom_en = ep; wr_en = 1'b0;
        #1;
        got = {vec_hit, unmapped, sel_ext, sel_eprom, sel_eeprom, sel_boot, sel_ram, sel_reg};
        exp = expect_out(a, md, ee, ep, m_ram, m_reg);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h mode=%b actual=%b expected=%b", tag, a, md, got, exp);
        end
    endtask

    task automatic write_map(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (a[15:12] == m_reg && a[11:0] == 12'h03D) begin
            m_ram = d[7:4];
            m_reg = d[3:0];
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset placement
        probe(16'h0000, 2'b00, 1, 1, "R1");
        probe(16'h1000, 2'b00, 1, 1, "R1");
        // R3 window edges
        probe(16'h01FF, 2'b00, 1, 1, "R3");
        probe(16'h103F, 2'b00, 1, 1, "R3");
        probe(16'h1040, 2'b00, 1, 1, "R8");
        probe(16'h0200, 2'b00, 1, 1, "R8");
        probe(16'h0200, 2'b01, 1, 1, "R7");
        probe(16'h0200, 2'b10, 1, 1, "R8");
        probe(16'h0200, 2'b11, 1, 1, "R7");

        // R2 write away from the register is ignored
        write_map(16'h1000, 8'h55);
        probe(16'h1000, 2'b00, 1, 1, "R2");
        probe(16'h5000, 2'b00, 1, 1, "R2");

        // R2 and R4 move both to page 3
        write_map(16'h103D, 8'h33);
        probe(16'h3000, 2'b00, 1, 1, "R4");
        probe(16'h303F, 2'b00, 1, 1, "R4");
        probe(16'h3040, 2'b00, 1, 1, "R4");
        probe(16'h31FF, 2'b00, 1, 1, "R4");
        probe(16'h3200, 2'b00, 1, 1, "R3");
        probe(16'h1000, 2'b00, 1, 1, "R2");
        probe(16'h0000, 2'b01, 1, 1, "R2");
        // stale address no longer hits the register
        write_map(16'h103D, 8'h01);
        probe(16'h3000, 2'b00, 1, 1, "R2");

        // R9 RAM over EPROM, register over boot page
        write_map(16'h303D, 8'hFB);
        probe(16'hF000, 2'b00, 1, 1, "R9");
        probe(16'hF1FF, 2'b00, 1, 1, "R9");
        probe(16'hF200, 2'b00, 1, 1, "R9");
        probe(16'hB000, 2'b10, 1, 1, "R9");
        probe(16'hB03F, 2'b10, 1, 1, "R9");

        // R5 configuration enables
        probe(16'hB600, 2'b00, 1, 1, "R5");
        probe(16'hB7FF, 2'b00, 0, 1, "R5");
        probe(16'hB600, 2'b01, 0, 1, "R5");
        probe(16'hD000, 2'b00, 1, 0, "R5");
        probe(16'hD000, 2'b11, 1, 0, "R5");

        // R6 boot ROM visibility
        probe(16'hBF00, 2'b00, 1, 1, "R6");
        probe(16'hBF00, 2'b01, 1, 1, "R6");
        probe(16'hBF00, 2'b10, 1, 1, "R6");
        probe(16'hBEFF, 2'b10, 1, 1, "R6");

        // R10 vector window per mode
        probe(16'hFFC0, 2'b00, 1, 1, "R10");
        probe(16'hFFBF, 2'b01, 1, 1, "R10");
        probe(16'hFFC0, 2'b10, 1, 1, "R10");
        probe(16'hBFC0, 2'b11, 1, 1, "R10");
        probe(16'hBFFF, 2'b00, 1, 1, "R10");

        // reset again restores the placement
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ram = 4'h0; m_reg = 4'h1;
        probe(16'h1000, 2'b00, 1, 1, "R1");
        probe(16'hF000, 2'b00, 1, 1, "R1");

        // random traffic, R9 and R11 over the whole map
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 3000; i++) begin
            int pick;
            pick = int'($urandom_range(0, 15));
            if (pick == 0) begin
                write_map({m_reg, 12'h03D}, 8'($urandom));
            end else if (pick == 1) begin
                write_map(16'($urandom), 8'($urandom));
            end else if (pick < 6) begin
                logic [3:0] pg;
                pg = 4'($urandom_range(0, 1)) ? m_reg : m_ram;
                probe({pg, 3'b000, 9'($urandom)}, 2'($urandom), 1'($urandom), 1'($urandom), "R9");
            end else begin
                probe(16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), "R11");
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule